// File: doc/BRIEF.md
# Dual-Read Single-Write CPU Register Bank

This block is the working register store of a small eight-bit-cell CPU datapath. It has 32 byte-wide locations. Two read ports, each selected by its own 5-bit address, drive two separate unidirectional output buses at the same time. A third 5-bit address steers the write bus into one location on a rising clock edge, but only when the load enable is high. The ALU and the rest of the datapath sit outside and connect only through these buses.

The low 22 locations are writable. They hold the byte halves of the 16-bit programmer registers: accumulator at 0–1, index at 2–3, stack pointer at 4–5 and program counter at 6–7, high byte first. The three-byte instruction register uses 8–10, and the scratch temporaries fill 11–21. The top ten locations are fixed constants that the microcode reads as operands. They cannot be altered.

The bank has no handshake. Read data is valid in the same cycle as its address. A write is always accepted at the edge where load is high, so there is no back-pressure on either side.

Top module: `cpu_regbank`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears every writable location 0–21 to 0x00. Reset takes priority over a write in the same cycle.
- R2: At a rising edge with load high and rst low, the value on wr_bus is stored in the location wr_sel when wr_sel is in 0–21.
- R3: At a rising edge with load low, no location changes, whatever wr_sel and wr_bus carry.
- R4: A write with wr_sel in 22–31 is discarded. Every location keeps its value, and reads of 22–31 still return their constants.
- R5: Locations 22 through 31 read as the constants 0x00, 0x01, 0x02, 0x03, 0x04, 0x08, 0xFA, 0xFC, 0xFE, 0xFF, at all times including during and after reset.
- R6: rd_a_bus shows the location at rd_a_sel and rd_b_bus shows the location at rd_b_sel, combinationally and independently. Both may select the same location.
- R7: A read of the location being written in the same cycle returns the value held before the edge. The new value appears only after the edge.
- R8: A write changes only the addressed location. All other locations keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_sel | input | 5 | Location driven onto rd_a_bus |
| rd_b_sel | input | 5 | Location driven onto rd_b_bus |
| wr_sel | input | 5 | Location written from wr_bus |
| load | input | 1 | Write enable for the current edge |
| wr_bus | input | 8 | Write data |
| rd_a_bus | output | 8 | Read data, port A |
| rd_b_bus | output | 8 | Read data, port B |

## Verification
The hardest case to reach from the ports is a single cycle that combines three things: a write, a read of that same location on one or both read ports, and a check that the read bus still shows the old value while the next cycle shows the new one. Uniform random addresses rarely line up like this. The stimulus therefore forces a read address to equal the write address in a fixed share of random cycles. It also biases the write address toward the constant range, so that discarded writes arrive often. A directed reset that arrives together with a write covers the priority case.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int unsigned RB_ADDR_W   = 5;
  localparam int unsigned RB_DATA_W   = 8;
  localparam int unsigned RB_WRITABLE = 22;

  // Named byte positions in the writable space (high byte first)
  localparam int unsigned RB_ACC_HI = 0;
  localparam int unsigned RB_IDX_HI = 2;
  localparam int unsigned RB_SP_HI  = 4;
  localparam int unsigned RB_PC_HI  = 6;
  localparam int unsigned RB_IR_0   = 8;
  localparam int unsigned RB_TMP_0  = 11;

  // Fixed operand values, indexed from the first constant location
  function automatic logic [7:0] rb_const(input int unsigned k);
    logic [7:0] v;
    case (k)
      0: v = 8'h00;
      1: v = 8'h01;
      2: v = 8'h02;
      3: v = 8'h03;
      4: v = 8'h04;
      5: v = 8'h08;
      6: v = 8'hFA;
      7: v = 8'hFC;
      8: v = 8'hFE;
      default: v = 8'hFF;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/rb_decoder.sv
module rb_decoder #(
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned NUM_OUT = 22
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_OUT-1:0] hit
);
  // Outputs exist only for writable locations, so constant addresses hit nothing
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_line
    assign hit[i] = en && (addr == ADDR_W'(i));
  end
endmodule

// File: rtl/rb_storage.sv
module rb_storage #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned WRITABLE = 22,
  parameter int unsigned NUM_REGS = 32
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [WRITABLE-1:0]                 wr_en,
  input  logic [DATA_W-1:0]                   wr_data,
  output logic [NUM_REGS-1:0][DATA_W-1:0]     words
);
  localparam int unsigned NUM_CONST = NUM_REGS - WRITABLE;

  logic [WRITABLE-1:0][DATA_W-1:0] store_q;

  for (genvar i = 0; i < WRITABLE; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst)           store_q[i] <= '0;
      else if (wr_en[i]) store_q[i] <= wr_data;
    end
    assign words[i] = store_q[i];
  end

  for (genvar k = 0; k < NUM_CONST; k++) begin : g_const
    assign words[WRITABLE + k] = DATA_W'(regbank_pkg::rb_const(k));
  end

  // R1: reset leaves every writable cell at zero
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (store_q == '0));

  // R3: with no enable asserted, storage holds
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !(|wr_en) |=> $stable(store_q));
endmodule

// File: rtl/rb_read_mux.sv
module rb_read_mux #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned NUM_REGS = 1 << ADDR_W
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] words,
  input  logic [ADDR_W-1:0]               sel,
  output logic [DATA_W-1:0]               dout
);
  assign dout = words[sel];
endmodule

// File: rtl/cpu_regbank.sv
module cpu_regbank #(
  parameter int unsigned ADDR_W   = regbank_pkg::RB_ADDR_W,
  parameter int unsigned DATA_W   = regbank_pkg::RB_DATA_W,
  parameter int unsigned WRITABLE = regbank_pkg::RB_WRITABLE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_a_sel,
  input  logic [ADDR_W-1:0] rd_b_sel,
  input  logic [ADDR_W-1:0] wr_sel,
  input  logic              load,
  input  logic [DATA_W-1:0] wr_bus,
  output logic [DATA_W-1:0] rd_a_bus,
  output logic [DATA_W-1:0] rd_b_bus
);
  localparam int unsigned NUM_REGS = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] FIRST_CONST = ADDR_W'(WRITABLE);

  logic [WRITABLE-1:0]             wr_en;
  logic [NUM_REGS-1:0][DATA_W-1:0] words;
  logic [ADDR_W-1:0]               rd_sel [2];
  logic [DATA_W-1:0]               rd_out [2];

  rb_decoder #(.ADDR_W(ADDR_W), .NUM_OUT(WRITABLE)) u_dec (
    .en(load), .addr(wr_sel), .hit(wr_en));

  rb_storage #(.DATA_W(DATA_W), .WRITABLE(WRITABLE), .NUM_REGS(NUM_REGS)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_bus), .words(words));

  assign rd_sel[0] = rd_a_sel;
  assign rd_sel[1] = rd_b_sel;

  for (genvar p = 0; p < 2; p++) begin : g_port
    rb_read_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
      .words(words), .sel(rd_sel[p]), .dout(rd_out[p]));
  end

  assign rd_a_bus = rd_out[0];
  assign rd_b_bus = rd_out[1];

  // R8: at most one location enabled per edge
  a_r8_single_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_en));

  // R2: a writable-range write lands in the addressed location
  a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
    (load && (wr_sel < FIRST_CONST)) |=> (words[$past(wr_sel)] == $past(wr_bus)));

  // R4: a write aimed at the constant range changes nothing
  a_r4_const_discard: assert property (@(posedge clk) disable iff (rst)
    (load && (wr_sel >= FIRST_CONST)) |=> $stable(words));
endmodule

// File: tb/cpu_regbank_tb_top.sv
module cpu_regbank_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] rd_a_sel = '0, rd_b_sel = '0, wr_sel = '0;
  logic       load = 1'b0;
  logic [7:0] wr_bus = '0;
  logic [7:0] rd_a_bus, rd_b_bus;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  logic [7:0] model [32];

  always #5 clk = ~clk;

  cpu_regbank dut_i (
    .clk(clk), .rst(rst), .rd_a_sel(rd_a_sel), .rd_b_sel(rd_b_sel),
    .wr_sel(wr_sel), .load(load), .wr_bus(wr_bus),
    .rd_a_bus(rd_a_bus), .rd_b_bus(rd_b_bus));

  function automatic logic [7:0] const_of(input int idx);
    case (idx)
      22: return 8'h00; 23: return 8'h01; 24: return 8'h02; 25: return 8'h03;
      26: return 8'h04; 27: return 8'h08; 28: return 8'hFA; 29: return 8'hFC;
      30: return 8'hFE; default: return 8'hFF;
    endcase
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < 32; i++) model[i] = (i < 22) ? 8'h00 : const_of(i);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one cycle; check reads before the edge, update the model after it
  task automatic cycle(input logic [4:0] sa, input logic [4:0] sb, input logic [4:0] sc,
                       input logic ld, input logic [7:0] d, input logic r, input string req);
    @(negedge clk);
    rd_a_sel = sa; rd_b_sel = sb; wr_sel = sc; load = ld; wr_bus = d; rst = r;
    #1;
    if (!r) begin
      check(req, rd_a_bus, model[sa]);
      check(req, rd_b_bus, model[sb]);
    end
    @(posedge clk);
    if (r) model_reset();
    else if (ld && sc < 5'd22) model[sc] = d;
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < 32; i += 2)
      cycle(5'(i), 5'(i + 1), 5'd0, 1'b0, 8'h00, 1'b0, req);
  endtask

  initial begin
    void'($urandom(32'h0000_5EED));
    model_reset();
    repeat (3) @(posedge clk);
    // R1 / R5: state after reset, constants included
    cycle(5'd0, 5'd22, 5'd0, 1'b0, 8'h00, 1'b0, "R1");
    read_all("R1_R5");

    // R2 / R6 / R8: distinct value into every writable location, then read all
    for (int i = 0; i < 22; i++)
      cycle(5'(i), 5'd31, 5'(i), 1'b1, 8'(8'hA0 + i * 3), 1'b0, "R2");
    read_all("R2_R8");

    // R4: writes aimed at constants are discarded
    for (int i = 22; i < 32; i++)
      cycle(5'(i), 5'd3, 5'(i), 1'b1, 8'h5A, 1'b0, "R4");
    read_all("R4_R5");

    // R3: load low leaves everything in place
    for (int i = 0; i < 22; i++)
      cycle(5'(i), 5'(21 - i), 5'(i), 1'b0, 8'hC3, 1'b0, "R3");

    // R7: same-cycle read shows old value, next cycle shows new
    cycle(5'd6, 5'd6, 5'd6, 1'b1, 8'h77, 1'b0, "R7");
    cycle(5'd6, 5'd7, 5'd0, 1'b0, 8'h00, 1'b0, "R7");

    // R1: reset together with a write; reset wins
    cycle(5'd0, 5'd0, 5'd5, 1'b1, 8'hEE, 1'b1, "R1");
    read_all("R1");

    // Random traffic with forced read/write collisions and constant-range bias
    for (int n = 0; n < 2000; n++) begin
      logic [4:0] sa, sb, sc;
      sc = 5'($urandom_range(0, 31));
      if ($urandom_range(0, 3) == 0) sc = 5'($urandom_range(22, 31));
      sa = 5'($urandom_range(0, 31));
      sb = 5'($urandom_range(0, 31));
      if ($urandom_range(0, 3) == 0) sa = sc;
      if ($urandom_range(0, 5) == 0) sb = sc;
      cycle(sa, sb, sc, 1'($urandom_range(0, 1)), 8'($urandom), 1'b0, "R6_R7_R8");
    end
    read_all("R2_R3_R4");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule